// File: doc/BRIEF.md
# Direct-Mapped Miss-Rate Meter

This block watches a stream of load and store effective addresses and reports how a direct-mapped data cache of a chosen size would behave on that stream. It keeps tags only: no data, no backing memory, no write policy. Each accepted address is looked up in a tag store. On a mismatch, or when the entry is empty, the reference counts as a miss and the entry takes the new tag.

Two 64-bit running totals, one for references and one for misses, are always visible on the ports, so the miss rate is their ratio. A clear input zeroes both totals and leaves the cached tags in place. A flush input empties the tag store and leaves the totals in place. One address can be accepted on every cycle, and each accepted address returns a hit/miss pulse on the next cycle.

Top module: `trace_miss_meter`

## Requirements
- R1: With the default geometry (64 KB capacity, 32-byte lines, 2048 entries), the entry index is address bits [15:5]. The stored tag is the address shifted right by 5. Two addresses that differ only in bits [4:0] hit the same entry.
- R2: After reset or a flush, every entry is empty. A reference to an empty entry is a miss and fills that entry.
- R3: A reference whose shifted address does not equal the stored tag of its entry is a miss and replaces that tag. This includes addresses that differ only above bit 15. A later reference to the evicted line misses again.
- R4: `ref_cnt_o` rises by exactly 1 for every accepted reference, hit or miss, in the cycle after acceptance.
- R5: `miss_cnt_o` rises by exactly 1 for every miss, in the cycle after acceptance. Both totals are 64 bits wide, and `miss_cnt_o` never exceeds `ref_cnt_o`.
- R6: `res_valid_o` is high for exactly the one cycle after each cycle with `ref_valid_i` high, and `res_miss_o` in that cycle gives the outcome (1 = miss). On cycles without `ref_valid_i`, `res_valid_o` stays low the next cycle and neither total changes.
- R7: A `clear_i` pulse sets both totals to 0 on the next cycle and leaves the tag store unchanged, so a line cached before the clear still hits after it.
- R8: A `flush_i` pulse empties every entry without changing either total.
- R9: When `clear_i` and `ref_valid_i` are high in the same cycle, the clear wins: both totals read 0 on the next cycle. The reference still produces its result pulse and still updates the tag store.
- R10: While `rst_ni` is low, both totals are 0 and `res_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_valid_i | input | 1 | An address is presented this cycle |
| ref_addr_i | input | 32 | Effective address of the load or store |
| flush_i | input | 1 | Empties every tag entry |
| clear_i | input | 1 | Zeroes both totals |
| res_valid_o | output | 1 | Lookup result pulse |
| res_miss_o | output | 1 | Result is a miss (1) or a hit (0) |
| ref_cnt_o | output | 64 | Accepted references since reset or clear |
| miss_cnt_o | output | 64 | Misses since reset or clear |

## Verification
Every result arrives one clock edge after its address is accepted. This covers the hit/miss pulse, both totals and the tag update. The bench drives inputs on the falling edge and samples outputs on the next falling edge, after the single register stage has updated, so addresses can go in back to back with each result read half a cycle after its edge. Clear and flush take effect at the same edge, so their effects are read on the following falling edge. Their effect on the tag store is then probed with one further reference, whose outcome appears one cycle later.

// File: rtl/tmm_pkg.sv
package tmm_pkg;
  typedef struct packed {
    logic valid;
    logic miss;
  } lookup_res_t;
endpackage

// File: rtl/tmm_tag_store.sv
module tmm_tag_store #(
  parameter int ENTRIES = 2048,
  parameter int IDX_W   = 11,
  parameter int TAG_W   = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             lkp_en_i,
  input  logic [IDX_W-1:0] lkp_idx_i,
  input  logic [TAG_W-1:0] lkp_tag_i,
  output logic             lkp_hit_o
);
  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];

  assign lkp_hit_o = vld_q[lkp_idx_i] && (tag_q[lkp_idx_i] == lkp_tag_i);

  // flush empties all; a same-cycle reference still installs its line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else begin
      if (flush_i) vld_q <= '0;
      if (lkp_en_i && !lkp_hit_o) vld_q[lkp_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (lkp_en_i && !lkp_hit_o) tag_q[lkp_idx_i] <= lkp_tag_i;
  end
endmodule

// File: rtl/tmm_counter.sv
module tmm_counter #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + ONE;
  end
endmodule

// File: rtl/trace_miss_meter.sv
module trace_miss_meter #(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 65536,
  parameter int LINE_BYTES  = 32,
  parameter int CNT_W       = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_valid_i,
  input  logic [ADDR_W-1:0] ref_addr_i,
  input  logic              flush_i,
  input  logic              clear_i,
  output logic              res_valid_o,
  output logic              res_miss_o,
  output logic [CNT_W-1:0]  ref_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o
);
  import tmm_pkg::*;

  localparam int OFS_W   = $clog2(LINE_BYTES);
  localparam int ENTRIES = CACHE_BYTES / LINE_BYTES;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int TAG_W   = ADDR_W - OFS_W;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             hit;
  lookup_res_t      res_q;

  assign idx = ref_addr_i[OFS_W +: IDX_W];
  assign tag = ref_addr_i[ADDR_W-1:OFS_W];

  tmm_tag_store #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush_i),
    .lkp_en_i (ref_valid_i),
    .lkp_idx_i(idx),
    .lkp_tag_i(tag),
    .lkp_hit_o(hit)
  );

  tmm_counter #(.W(CNT_W)) u_ref_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clear_i),
    .inc_i (ref_valid_i), .cnt_o(ref_cnt_o)
  );

  tmm_counter #(.W(CNT_W)) u_miss_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clear_i),
    .inc_i (ref_valid_i && !hit), .cnt_o(miss_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
    end else begin
      res_q.valid <= ref_valid_i;
      res_q.miss  <= ref_valid_i && !hit;
    end
  end

  assign res_valid_o = res_q.valid;
  assign res_miss_o  = res_q.miss;
endmodule

// File: rtl/trace_miss_meter_chk.sv
module trace_miss_meter_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ref_valid_i,
  input logic             clear_i,
  input logic             res_valid_o,
  input logic             res_miss_o,
  input logic [CNT_W-1:0] ref_cnt_o,
  input logic [CNT_W-1:0] miss_cnt_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  a_r4_ref_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_valid_i && !clear_i) |=> ref_cnt_o == $past(ref_cnt_o) + ONE);

  a_r5_miss_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_valid_i && !clear_i) |=>
      miss_cnt_o == $past(miss_cnt_o) + (res_miss_o ? ONE : '0));

  a_r5_miss_le_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_cnt_o <= ref_cnt_o);

  a_r6_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_valid_i |=> res_valid_o);

  a_r6_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_valid_i && !clear_i) |=>
      !res_valid_o && $stable(ref_cnt_o) && $stable(miss_cnt_o));

  a_r6_miss_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_miss_o |-> res_valid_o);

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (ref_cnt_o == '0) && (miss_cnt_o == '0));
endmodule

bind trace_miss_meter trace_miss_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ref_valid_i(ref_valid_i),
  .clear_i    (clear_i),
  .res_valid_o(res_valid_o),
  .res_miss_o (res_miss_o),
  .ref_cnt_o  (ref_cnt_o),
  .miss_cnt_o (miss_cnt_o)
);

// File: tb/tb_trace_miss_meter.sv
module tb_trace_miss_meter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref_valid_i = 1'b0;
  logic [31:0] ref_addr_i = '0;
  logic        flush_i = 1'b0;
  logic        clear_i = 1'b0;
  logic        res_valid_o, res_miss_o;
  logic [63:0] ref_cnt_o, miss_cnt_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  trace_miss_meter dut (.*);

  // {expected miss, address}; run from an empty store
  localparam int NV = 12;
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 32'h0000_0000},  // R2 empty
    {1'b0, 32'h0000_0004},  // R1 same line
    {1'b0, 32'h0000_001F},  // R1 last byte
    {1'b1, 32'h0000_0020},  // R2 index 1
    {1'b1, 32'h0001_0000},  // R3 index 0, new tag
    {1'b1, 32'h0000_0000},  // R3 evicted
    {1'b0, 32'h0000_0010},
    {1'b1, 32'h0000_FFE0},  // R1 index 2047
    {1'b0, 32'h0000_FFFF},
    {1'b1, 32'h8000_0020},  // R3 high bits only
    {1'b1, 32'h0000_0020},
    {1'b0, 32'h0000_0024}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic one_ref(input logic [31:0] a, input logic clr, input logic exp_miss, input string req);
    @(negedge clk_i);
    ref_valid_i = 1'b1; ref_addr_i = a; clear_i = clr;
    @(negedge clk_i);
    ref_valid_i = 1'b0; clear_i = 1'b0;
    chk(res_valid_o === 1'b1, req, 64'(res_valid_o), 64'd1);
    chk(res_miss_o === exp_miss, req, 64'(res_miss_o), 64'(exp_miss));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int exp_miss_tot;
    exp_miss_tot = 0;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(ref_cnt_o == 0, "R10", ref_cnt_o, 0);
    chk(miss_cnt_o == 0, "R10", miss_cnt_o, 0);
    chk(res_valid_o == 1'b0, "R10", 64'(res_valid_o), 0);
    rst_ni = 1'b1;

    // table walk, back to back
    @(negedge clk_i);
    ref_valid_i = 1'b1; ref_addr_i = VEC[0][31:0];
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      chk(res_valid_o === 1'b1, "R6", 64'(res_valid_o), 1);
      chk(res_miss_o === VEC[i][32], "R1/R2/R3", 64'(res_miss_o), 64'(VEC[i][32]));
      chk(ref_cnt_o == 64'(i + 1), "R4", ref_cnt_o, 64'(i + 1));
      if (VEC[i][32]) exp_miss_tot++;
      chk(miss_cnt_o == 64'(exp_miss_tot), "R5", miss_cnt_o, 64'(exp_miss_tot));
      if (i < NV - 1) ref_addr_i = VEC[i+1][31:0];
      else ref_valid_i = 1'b0;
    end

    // R6 idle: no pulse, totals held
    @(negedge clk_i);
    chk(res_valid_o === 1'b0, "R6", 64'(res_valid_o), 0);
    chk(ref_cnt_o == 64'(NV), "R6", ref_cnt_o, 64'(NV));
    chk(miss_cnt_o == 64'(exp_miss_tot), "R6", miss_cnt_o, 64'(exp_miss_tot));

    // R7 clear keeps tags
    @(negedge clk_i); clear_i = 1'b1;
    @(negedge clk_i); clear_i = 1'b0;
    chk(ref_cnt_o == 0 && miss_cnt_o == 0, "R7", ref_cnt_o | miss_cnt_o, 0);
    one_ref(32'h0000_0024, 1'b0, 1'b0, "R7");
    chk(ref_cnt_o == 1 && miss_cnt_o == 0, "R7", {ref_cnt_o[31:0], miss_cnt_o[31:0]}, 64'h1_0000_0000);

    // R8 flush keeps totals, empties store
    @(negedge clk_i); flush_i = 1'b1;
    @(negedge clk_i); flush_i = 1'b0;
    chk(ref_cnt_o == 1 && miss_cnt_o == 0, "R8", ref_cnt_o, 1);
    one_ref(32'h0000_0024, 1'b0, 1'b1, "R8");
    one_ref(32'h0000_FFE0, 1'b0, 1'b1, "R8");
    chk(miss_cnt_o == 2, "R8", miss_cnt_o, 2);

    // R9 clear with reference: clear wins, line installed
    one_ref(32'h0004_0040, 1'b1, 1'b1, "R9");
    chk(ref_cnt_o == 0 && miss_cnt_o == 0, "R9", ref_cnt_o | miss_cnt_o, 0);
    one_ref(32'h0004_0040, 1'b0, 1'b0, "R9");
    chk(ref_cnt_o == 1 && miss_cnt_o == 0, "R9", ref_cnt_o, 1);

    // R10 reset mid-run
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    chk(ref_cnt_o == 0 && miss_cnt_o == 0, "R10", ref_cnt_o | miss_cnt_o, 0);
    rst_ni = 1'b1;
    one_ref(32'h0004_0040, 1'b0, 1'b1, "R2");

    finish_run();
  end
endmodule